// File: doc/BRIEF.md
# Dual-Rail Memory Supply Governor

This controller picks which of two supply rails powers a memory array and decides when two write-holding buffers may push their contents into that array. Reads run on the low rail. Writes need the high rail. One buffer collects core-side stores. The other collects evictions headed for writeback. While neither buffer has filled, the array stays on the low rail. When either buffer fills, the governor moves the array to the high rail. It waits until an external comparator reports that the rail has settled at a level safe for writing, then grants release to the filled buffers one after another. The high rail is held until every buffer that was granted release reports that it is empty. The governor then steps back down to the low rail.

The two rail-enable outputs are driven from one registered state. They are never on together, and each change of rail passes through one cycle in which both are off. The comparator is asynchronous to the clock, so it passes through a synchronizer before any grant depends on it. A pending core read halts the core-side release so the read is served first. The writeback release never waits for reads.

Top module: `rail_governor`

## Requirements
- R1: From the low-rail state, a full flag on either buffer leads to one cycle with both rail enables off, followed by `rail_hi_en`=1 and `rail_lo_en`=0.
- R2: With neither buffer full and nothing left to drain, the block selects the low rail (`rail_lo_en`=1, `rail_hi_en`=0).
- R3: `rail_hi_en` and `rail_lo_en` are never 1 in the same cycle, and every change of rail is preceded by exactly one cycle in which both are 0.
- R4: A buffer's grant is 1 only while the high rail is selected, the synchronized comparator reports a safe level, and that buffer has been seen full and has not yet drained. While the comparator reports unsafe, both grants stay 0.
- R5: `rail_ok` passes through a two-flop synchronizer. A grant reacts to a change of `rail_ok` only after the second rising clock edge that follows the change.
- R6: While `rd_req`=1, `core_grant` is 0 in that same cycle. `wb_grant` does not depend on `rd_req`.
- R7: When both buffers are pending, the core-side buffer is granted first. `wb_grant` becomes 1 only after the core side has drained, or while a read is halting the core side. The two grants are never 1 together.
- R8: Once on the high rail, the block stays there until every pending buffer has reported empty (`*_empty`=1) while granted. Only then does it leave the high rail, through the gap of R3.
- R9: After reset, `rail_lo_en`=1, `rail_hi_en`=0, and both grants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_full | input | 1 | Core-side write buffer has reached its aggregation length |
| wb_full | input | 1 | Writeback buffer has reached its aggregation length |
| core_empty | input | 1 | Core-side buffer holds no data |
| wb_empty | input | 1 | Writeback buffer holds no data |
| rd_req | input | 1 | A core read to the array is pending |
| rail_ok | input | 1 | Asynchronous comparator: rail at a write-safe level |
| rail_hi_en | output | 1 | Enable for the high-rail power switch |
| rail_lo_en | output | 1 | Enable for the low-rail power switch |
| core_grant | output | 1 | Core-side buffer may release writes |
| wb_grant | output | 1 | Writeback buffer may release writes |

## Verification
A wrong rail state shows at the enables at the next rising edge, either as both enables high, as a missing one-cycle gap, or as a rail change that comes too early. A pending flag that is set or cleared wrongly shows as a grant that appears without a full flag, or as a high rail that is dropped while data remains, no later than the following cycle. A synchronizer with the wrong depth moves the first grant by one cycle relative to the comparator edge. A wrong priority shows as the writeback grant rising while the core side is still pending and no read is active.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [1:0] {
        RG_LOW    = 2'd0,
        RG_GAP_UP = 2'd1,
        RG_HIGH   = 2'd2,
        RG_GAP_DN = 2'd3
    } rg_state_e;

endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sh = {s_q.sh[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q.sh[STAGES-1];

    // R5: a rising output traces back to the input STAGES edges earlier
    p_sync_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout) |-> $past(din, STAGES));
endmodule

// File: rtl/rg_seq.sv
module rg_seq
    import rg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_full,
    input  logic drained,
    output logic hi_en,
    output logic lo_en,
    output logic in_high
);
    typedef struct packed {
        rg_state_e st;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            RG_LOW:    if (any_full) r_d.st = RG_GAP_UP;
            RG_GAP_UP: r_d.st = RG_HIGH;
            RG_HIGH:   if (drained) r_d.st = RG_GAP_DN;
            RG_GAP_DN: r_d.st = RG_LOW;
            default:   r_d.st = RG_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.st <= RG_LOW;
        else        r_q    <= r_d;
    end

    assign hi_en   = (r_q.st == RG_HIGH);
    assign lo_en   = (r_q.st == RG_LOW);
    assign in_high = hi_en;

    p_rails_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_en && lo_en));
    p_gap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_en) |-> $past(!lo_en));
    p_gap_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_en) |-> $past(!hi_en));
    p_leave_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en && any_full) |=> !lo_en && !hi_en);
endmodule

// File: rtl/rg_arbiter.sv
module rg_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic in_high,
    input  logic ok,
    input  logic rd_req,
    input  logic core_full,
    input  logic wb_full,
    input  logic core_empty,
    input  logic wb_empty,
    output logic core_grant,
    output logic wb_grant,
    output logic drained
);
    typedef struct packed {
        logic core_pend;
        logic wb_pend;
    } arb_t;

    arb_t a_d, a_q;
    logic release_ok;
    logic core_active;

    assign release_ok  = in_high && ok;
    assign core_active = a_q.core_pend && !rd_req;
    assign core_grant  = release_ok && core_active;
    assign wb_grant    = release_ok && a_q.wb_pend && !core_active;
    assign drained     = !a_q.core_pend && !a_q.wb_pend && !core_full && !wb_full;

    always_comb begin
        a_d = a_q;
        a_d.core_pend = (a_q.core_pend || core_full) && !(core_grant && core_empty);
        a_d.wb_pend   = (a_q.wb_pend || wb_full) && !(wb_grant && wb_empty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_grant && wb_grant));
    p_rd_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !core_grant);
    p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q.core_pend && !(core_grant && core_empty)) |=> a_q.core_pend);
endmodule

// File: rtl/rail_governor.sv
module rail_governor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_full,
    input  logic wb_full,
    input  logic core_empty,
    input  logic wb_empty,
    input  logic rd_req,
    input  logic rail_ok,
    output logic rail_hi_en,
    output logic rail_lo_en,
    output logic core_grant,
    output logic wb_grant
);
    logic ok_sync;
    logic in_high;
    logic drained;

    rg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rail_ok),
        .dout (ok_sync)
    );

    rg_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_full(core_full || wb_full),
        .drained (drained),
        .hi_en   (rail_hi_en),
        .lo_en   (rail_lo_en),
        .in_high (in_high)
    );

    rg_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_high   (in_high),
        .ok        (ok_sync),
        .rd_req    (rd_req),
        .core_full (core_full),
        .wb_full   (wb_full),
        .core_empty(core_empty),
        .wb_empty  (wb_empty),
        .core_grant(core_grant),
        .wb_grant  (wb_grant),
        .drained   (drained)
    );

    p_grant_on_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_grant || wb_grant) |-> (rail_hi_en && !rail_lo_en && ok_sync));
endmodule

// File: tb/rail_governor_tb.sv
module rail_governor_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_full = 0, wb_full = 0, core_empty = 1, wb_empty = 1;
    logic rd_req = 0, rail_ok = 0;
    logic rail_hi_en, rail_lo_en, core_grant, wb_grant;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rail_governor u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_full(core_full), .wb_full(wb_full),
        .core_empty(core_empty), .wb_empty(wb_empty),
        .rd_req(rd_req), .rail_ok(rail_ok),
        .rail_hi_en(rail_hi_en), .rail_lo_en(rail_lo_en),
        .core_grant(core_grant), .wb_grant(wb_grant)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic rails(input string tag, input logic hi, input logic lo);
        chk({tag, " hi"}, rail_hi_en, hi);
        chk({tag, " lo"}, rail_lo_en, lo);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // drain everything and return to the low rail with comparator low
    task automatic recover();
        core_full = 0; wb_full = 0; core_empty = 1; wb_empty = 1;
        rd_req = 0; rail_ok = 1;
        for (int k = 0; k < 8; k++) step();
        rail_ok = 0;
        for (int k = 0; k < 3; k++) step();
    endtask

    // R3 monitor: exclusive rails and one-cycle gap on every change
    logic prev_hi = 0, prev_lo = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 exclusive", rail_hi_en && rail_lo_en, 1'b0);
            if (rail_hi_en && !prev_hi) chk("R3 gap up", prev_lo, 1'b0);
            if (rail_lo_en && !prev_lo) chk("R3 gap dn", prev_hi, 1'b0);
        end
        prev_hi = rail_hi_en;
        prev_lo = rail_lo_en;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #35;
        // R9 reset state
        rails("R9 reset", 1'b0, 1'b1);
        chk("R9 core_grant", core_grant, 1'b0);
        chk("R9 wb_grant", wb_grant, 1'b0);
        rst_n = 1;
        step();
        rails("R2 idle", 1'b0, 1'b1);

        // Sweep of full-flag combinations from the low rail (R1, R2)
        for (int i = 0; i < 4; i++) begin
            core_full = i[0]; wb_full = i[1];
            core_empty = !i[0]; wb_empty = !i[1];
            step();
            if (i == 0) rails("R2 no full", 1'b0, 1'b1);
            else begin
                rails("R1 gap", 1'b0, 1'b0);
                step();
                rails("R1 high", 1'b1, 1'b0);
                chk("R4 unsafe core", core_grant, 1'b0);
                chk("R4 unsafe wb", wb_grant, 1'b0);
                step();
                rails("R8 hold unsafe", 1'b1, 1'b0);
            end
            recover();
            rails("R2 back low", 1'b0, 1'b1);
        end

        // Core path: sync latency, read halt, drain hold
        core_full = 1; core_empty = 0;
        step(); step();
        rails("R1 core high", 1'b1, 1'b0);
        rail_ok = 1;
        step();
        chk("R5 one edge no grant", core_grant, 1'b0);
        step();
        chk("R5 two edges grant", core_grant, 1'b1);
        rd_req = 1; #1;
        chk("R6 read halts core", core_grant, 1'b0);
        rd_req = 0; #1;
        chk("R6 core resumes", core_grant, 1'b1);
        core_full = 0;
        step(); step();
        rails("R8 not drained", 1'b1, 1'b0);
        chk("R8 still granted", core_grant, 1'b1);
        core_empty = 1;
        step();
        rails("R8 drain edge", 1'b1, 1'b0);
        chk("R8 grant dropped", core_grant, 1'b0);
        step();
        rails("R8 gap dn", 1'b0, 1'b0);
        step();
        rails("R2 low after drain", 1'b0, 1'b1);
        rail_ok = 0;
        step(); step(); step();

        // Both buffers: order and read interaction
        core_full = 1; wb_full = 1; core_empty = 0; wb_empty = 0; rail_ok = 1;
        step(); step();
        rails("R1 both high", 1'b1, 1'b0);
        chk("R7 core first", core_grant, 1'b1);
        chk("R7 wb waits", wb_grant, 1'b0);
        rd_req = 1; #1;
        chk("R6 core halted", core_grant, 1'b0);
        chk("R6 wb not halted", wb_grant, 1'b1);
        rd_req = 0; #1;
        chk("R7 back to core", core_grant, 1'b1);
        chk("R7 wb off", wb_grant, 1'b0);
        // comparator drops: grants cleared after sync latency
        rail_ok = 0;
        step(); step();
        chk("R4 unsafe core", core_grant, 1'b0);
        chk("R4 unsafe wb", wb_grant, 1'b0);
        rails("R8 hold", 1'b1, 1'b0);
        rail_ok = 1;
        step(); step();
        chk("R4 safe again", core_grant, 1'b1);
        core_full = 0; core_empty = 1;
        step();
        chk("R7 wb after core", wb_grant, 1'b1);
        chk("R7 core done", core_grant, 1'b0);
        rd_req = 1; #1;
        chk("R6 wb ignores read", wb_grant, 1'b1);
        rd_req = 0;
        wb_full = 0; wb_empty = 1;
        step();
        rails("R8 wb drain edge", 1'b1, 1'b0);
        chk("R8 wb grant off", wb_grant, 1'b0);
        step();
        rails("R8 gap", 1'b0, 1'b0);
        step();
        rails("R2 final low", 1'b0, 1'b1);
        chk("R9 grants idle", core_grant | wb_grant, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule